// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the first six bytes of each incoming Ethernet frame and decides whether the frame should be kept. It is fed one byte per clock with a valid strobe and a start-of-frame flag on the first byte. It compares the destination address against a programmed station address, recognises broadcast and group (multicast) addresses, and looks multicast addresses up in a 64-entry hash table. The hash index is taken from a CRC-32 computed over the six address bytes as they arrive. Static control inputs choose promiscuous operation, turn address filtering on or off, and enable the unicast, broadcast, multicast and hash checks one by one.

The decision appears on `dec_valid`/`dec_accept` one clock after the sixth address byte and stays there until the next start of frame. A small state machine tracks the frame. Its states are `ST_IDLE` (no frame seen since reset), `ST_COLLECT` (address bytes are arriving) and `ST_DONE` (a decision is held). Its transitions are:

- `SOF_SHORT`: any state to `ST_COLLECT`, on a start-of-frame byte.
- `ADDR_END`: `ST_COLLECT` to `ST_DONE`, on the sixth byte.
- `WAIT`: stay in the current state when neither of the above occurs.

Payload bytes after the address are ignored. The receive path uses the decision to drop or keep the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0.
- R2: Only cycles with `in_valid`=1 carry a byte. The byte with `in_sof`=1 is address byte 0. `dec_valid` rises one clock after the sixth byte (byte 5), whatever idle cycles lie between bytes. The decision then holds, unchanged by later bytes or control changes, until the clock after the next start-of-frame byte, which clears both outputs. `dec_accept` is 0 whenever `dec_valid` is 0. Control inputs are sampled in the cycle of byte 5.
- R3: With `cfg_promisc`=1, every frame is accepted.
- R4: With `cfg_promisc`=0 and `cfg_addr_filt`=0, every frame is accepted.
- R5: When filtering is active, a unicast frame (bit 0 of byte 0 clear) with `cfg_ucast_chk`=1 is accepted only if all six bytes equal the station address. Byte 0 is `cfg_sta_hi[23:16]`, byte 1 is `cfg_sta_hi[15:8]`, byte 2 is `cfg_sta_hi[7:0]`, byte 3 is `cfg_sta_lo[23:16]`, byte 4 is `cfg_sta_lo[15:8]`, and byte 5 is `cfg_sta_lo[7:0]`.
- R6: When filtering is active and `cfg_ucast_chk`=0, unicast frames are accepted.
- R7: When filtering is active, a frame whose six bytes are all 0xFF is accepted exactly when `cfg_bcast_en`=1. The hash table plays no part.
- R8: When filtering is active, a multicast (non-broadcast, bit 0 of byte 0 set) frame is rejected when `cfg_mcast_en`=0.
- R9: When filtering is active, a multicast frame with `cfg_mcast_en`=1 and `cfg_hash_en`=1 is accepted exactly when the selected table bit is set.
  - The CRC register starts at all ones. Each byte enters least significant bit first. For each bit, the feedback is the CRC's bit 31 XOR the data bit; the CRC shifts left one place and is XORed with 0x04C11DB7 when the feedback is 1. There is no final inversion.
  - The index is the CRC's bits 31:26 after byte 5. Index bit 5 selects `cfg_hash_hi` (1) or `cfg_hash_lo` (0), and index bits 4:0 select the bit within it.
- R10: When filtering is active, a multicast frame with `cfg_mcast_en`=1 and `cfg_hash_en`=0 is accepted.
- R11: With both hash words all ones and hashing on, every multicast frame is accepted.
- R12: A start-of-frame byte that arrives before byte 5 restarts address collection. The decision follows the new frame only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the first byte of a frame (with in_valid) |
| in_data | input | 8 | Received byte |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_addr_filt | input | 1 | Enable destination filtering |
| cfg_ucast_chk | input | 1 | Compare unicast addresses to the station address |
| cfg_mcast_en | input | 1 | Allow multicast frames |
| cfg_hash_en | input | 1 | Gate multicast through the hash table |
| cfg_bcast_en | input | 1 | Allow broadcast frames |
| cfg_sta_hi | input | 24 | Station address bytes 0..2 |
| cfg_sta_lo | input | 24 | Station address bytes 3..5 |
| cfg_hash_lo | input | 32 | Hash table entries 0..31 |
| cfg_hash_hi | input | 32 | Hash table entries 32..63 |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | Frame accepted |

## Verification
The properties assume that the control inputs are steady in the cycle of byte 5. They also assume that `in_sof` matters only together with `in_valid`. The stimulus changes configuration only between frames, at the falling edge, and raises `in_sof` only on a valid first byte. Within those limits it inserts idle gaps, trailing payload, and frames truncated before byte 5.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2
    } rxaf_state_e;

    typedef enum logic [1:0] {
        CL_UNICAST   = 2'd0,
        CL_GROUP     = 2'd1,
        CL_BROADCAST = 2'd2
    } rxaf_class_e;

    typedef struct packed {
        logic promisc;
        logic addr_filt;
        logic ucast_chk;
        logic mcast_en;
        logic hash_en;
        logic bcast_en;
    } rxaf_ctrl_t;

endpackage

// File: rtl/rxaf_crc.sv
module rxaf_crc #(
    parameter int          CRC_W    = 32,
    parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
    parameter int          BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_nx
);
    logic [CRC_W-1:0] crc_q;

    // Serial CRC, data bits taken least significant first.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = first ? {CRC_W{1'b1}} : crc_q;
        for (int b = 0; b < BYTE_W; b++) begin
            fb  = acc[CRC_W-1] ^ data[b];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_POLY[CRC_W-1:0];
            end
        end
        crc_nx = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= {CRC_W{1'b1}};
        end else if (take) begin
            crc_q <= crc_nx;
        end
    end
endmodule

// File: rtl/rxaf_addr_cmp.sv
module rxaf_addr_cmp #(
    parameter int N_BYTES = 6,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 first,
    input  logic [IDX_W-1:0]     idx,
    input  logic [7:0]           data,
    input  logic [8*N_BYTES-1:0] station,
    output logic                 match_nx,
    output logic                 bcast_nx,
    output logic                 group_nx
);
    logic [7:0] sta_b [N_BYTES];
    logic [7:0] expect_b;
    logic       match_q;
    logic       bcast_q;
    logic       group_q;

    // Byte 0 sits in the most significant octet.
    for (genvar g = 0; g < N_BYTES; g++) begin : g_split
        assign sta_b[g] = station[8*(N_BYTES-1-g) +: 8];
    end

    always_comb begin
        expect_b = 8'h00;
        for (int k = 0; k < N_BYTES; k++) begin
            if (int'(idx) == k) begin
                expect_b = sta_b[k];
            end
        end
    end

    assign match_nx = (first ? 1'b1 : match_q) & (data == expect_b);
    assign bcast_nx = (first ? 1'b1 : bcast_q) & (data == 8'hFF);
    assign group_nx = first ? data[0] : group_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            bcast_q <= 1'b0;
            group_q <= 1'b0;
        end else if (take) begin
            match_q <= match_nx;
            bcast_q <= bcast_nx;
            group_q <= group_nx;
        end
    end
endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int HASH_IDX_W = 6,
    parameter int TABLE_BITS = 1 << HASH_IDX_W
) (
    input  rxaf_ctrl_t            ctrl,
    input  logic                  match,
    input  logic                  bcast,
    input  logic                  group,
    input  logic [HASH_IDX_W-1:0] hidx,
    input  logic [TABLE_BITS-1:0] table_bits,
    output logic                  accept
);
    rxaf_class_e kind;
    logic        hash_hit;

    always_comb begin
        if (bcast) begin
            kind = CL_BROADCAST;
        end else if (group) begin
            kind = CL_GROUP;
        end else begin
            kind = CL_UNICAST;
        end
    end

    assign hash_hit = table_bits[hidx];

    always_comb begin
        if (ctrl.promisc || !ctrl.addr_filt) begin
            accept = 1'b1;
        end else begin
            unique case (kind)
                CL_BROADCAST: accept = ctrl.bcast_en;
                CL_GROUP:     accept = ctrl.mcast_en & (!ctrl.hash_en | hash_hit);
                CL_UNICAST:   accept = !ctrl.ucast_chk | match;
                default:      accept = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int          ADDR_BYTES = 6,
    parameter int          HASH_IDX_W = 6,
    parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_data,
    input  logic        cfg_promisc,
    input  logic        cfg_addr_filt,
    input  logic        cfg_ucast_chk,
    input  logic        cfg_mcast_en,
    input  logic        cfg_hash_en,
    input  logic        cfg_bcast_en,
    input  logic [23:0] cfg_sta_hi,
    input  logic [23:0] cfg_sta_lo,
    input  logic [31:0] cfg_hash_lo,
    input  logic [31:0] cfg_hash_hi,
    output logic        dec_valid,
    output logic        dec_accept
);
    localparam int CRC_W      = 32;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int TABLE_BITS = 1 << HASH_IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    rxaf_state_e            state_q;
    rxaf_state_e            state_d;
    logic [IDX_W-1:0]       cnt_q;
    logic [IDX_W-1:0]       cur_idx;
    logic                   first;
    logic                   take;
    logic                   last;
    logic [CRC_W-1:0]       crc_nx;
    logic                   match_nx;
    logic                   bcast_nx;
    logic                   group_nx;
    logic                   accept_c;
    rxaf_ctrl_t             ctrl;
    logic [TABLE_BITS-1:0]  table_bits;

    assign first   = in_valid && in_sof;
    assign take    = in_valid && (in_sof || state_q == ST_COLLECT);
    assign cur_idx = first ? '0 : cnt_q;
    assign last    = take && (cur_idx == LAST_IDX);

    assign ctrl.promisc   = cfg_promisc;
    assign ctrl.addr_filt = cfg_addr_filt;
    assign ctrl.ucast_chk = cfg_ucast_chk;
    assign ctrl.mcast_en  = cfg_mcast_en;
    assign ctrl.hash_en   = cfg_hash_en;
    assign ctrl.bcast_en  = cfg_bcast_en;
    assign table_bits     = TABLE_BITS'({cfg_hash_hi, cfg_hash_lo});

    rxaf_crc #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY),
        .BYTE_W   (8)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .first  (first),
        .data   (in_data),
        .crc_nx (crc_nx)
    );

    rxaf_addr_cmp #(
        .N_BYTES (ADDR_BYTES),
        .IDX_W   (IDX_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .idx      (cur_idx),
        .data     (in_data),
        .station  ((8*ADDR_BYTES)'({cfg_sta_hi, cfg_sta_lo})),
        .match_nx (match_nx),
        .bcast_nx (bcast_nx),
        .group_nx (group_nx)
    );

    rxaf_classify #(
        .HASH_IDX_W (HASH_IDX_W),
        .TABLE_BITS (TABLE_BITS)
    ) u_cls (
        .ctrl       (ctrl),
        .match      (match_nx),
        .bcast      (bcast_nx),
        .group      (group_nx),
        .hidx       (crc_nx[CRC_W-1 -: HASH_IDX_W]),
        .table_bits (table_bits),
        .accept     (accept_c)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_COLLECT, ST_DONE: begin
                if (last) begin
                    state_d = ST_DONE;
                end else if (first) begin
                    state_d = ST_COLLECT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and byte counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cnt_q <= cur_idx + IDX_W'(1);
            end
        end
    end

    // Decision outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (last) begin
            dec_valid  <= 1'b1;
            dec_accept <= accept_c;
        end else if (first) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end
    end
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic cfg_promisc,
    input logic cfg_addr_filt,
    input logic cfg_bcast_en,
    input logic dec_valid,
    input logic dec_accept,
    input logic bcast_seen,
    input logic last_byte
);
    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof && !last_byte |=> !dec_valid && !dec_accept); // R2

    AST_DECISION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !(in_valid && in_sof) |=> dec_valid && $stable(dec_accept)); // R2

    AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte && cfg_promisc |=> dec_valid && dec_accept); // R3

    AST_NOFILTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte && !cfg_addr_filt |=> dec_valid && dec_accept); // R4

    AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte && bcast_seen && cfg_addr_filt && !cfg_promisc && !cfg_bcast_en
        |=> !dec_accept); // R7

    AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte && bcast_seen && cfg_bcast_en |=> dec_accept); // R7
endmodule

bind rx_addr_filter rxaf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .cfg_promisc   (cfg_promisc),
    .cfg_addr_filt (cfg_addr_filt),
    .cfg_bcast_en  (cfg_bcast_en),
    .dec_valid     (dec_valid),
    .dec_accept    (dec_accept),
    .bcast_seen    (bcast_nx),
    .last_byte     (last)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        cfg_promisc = 1'b0;
    logic        cfg_addr_filt = 1'b1;
    logic        cfg_ucast_chk = 1'b1;
    logic        cfg_mcast_en = 1'b1;
    logic        cfg_hash_en = 1'b1;
    logic        cfg_bcast_en = 1'b1;
    logic [23:0] cfg_sta_hi = 24'h02_11_22;
    logic [23:0] cfg_sta_lo = 24'h33_44_55;
    logic [31:0] cfg_hash_lo = 32'h0;
    logic [31:0] cfg_hash_hi = 32'h0;
    logic        dec_valid;
    logic        dec_accept;

    always #5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .cfg_promisc(cfg_promisc), .cfg_addr_filt(cfg_addr_filt), .cfg_ucast_chk(cfg_ucast_chk),
        .cfg_mcast_en(cfg_mcast_en), .cfg_hash_en(cfg_hash_en), .cfg_bcast_en(cfg_bcast_en),
        .cfg_sta_hi(cfg_sta_hi), .cfg_sta_lo(cfg_sta_lo),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    running = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    bit       exp_v = 1'b0;
    bit       exp_a = 1'b0;
    bit       coll = 1'b0;
    bit [7:0] got[$];

    function automatic bit [5:0] ref_idx(bit [47:0] da);
        bit [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            bit [7:0] b = da[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                bit fb = c[31] ^ b[k];
                c = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic bit ref_accept(bit [47:0] da);
        bit [63:0] tbl;
        if (cfg_promisc) return 1'b1;
        if (!cfg_addr_filt) return 1'b1;
        if (da == 48'hFFFF_FFFF_FFFF) return cfg_bcast_en;
        if (da[40]) begin
            if (!cfg_mcast_en) return 1'b0;
            if (!cfg_hash_en) return 1'b1;
            tbl = {cfg_hash_hi, cfg_hash_lo};
            return tbl[ref_idx(da)];
        end
        if (!cfg_ucast_chk) return 1'b1;
        return da == {cfg_sta_hi, cfg_sta_lo};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 1'b0; exp_a = 1'b0; coll = 1'b0; got.delete();
        end else if (in_valid && in_sof) begin
            got.delete(); got.push_back(in_data);
            exp_v = 1'b0; exp_a = 1'b0; coll = 1'b1;
        end else if (in_valid && coll) begin
            got.push_back(in_data);
            if (got.size() == 6) begin
                bit [47:0] da;
                for (int i = 0; i < 6; i++) da[47-8*i -: 8] = got[i];
                exp_v = 1'b1; exp_a = ref_accept(da); coll = 1'b0;
            end
        end
    end

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (running) begin
            n_cmp++;
            if (dec_valid !== exp_v || dec_accept !== (exp_v & exp_a)) begin
                n_bad++;
                $display("FAIL %s: valid/accept actual %b/%b expected %b/%b",
                         cur_req, dec_valid, dec_accept, exp_v, exp_v & exp_a);
            end
        end
    end

    task automatic chk(string r, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", r, act, exp);
        end
    endtask

    task automatic chk_dec(string r, bit exp);
        chk(r, dec_valid, 1'b1);
        chk(r, dec_accept, exp);
    endtask

    task automatic send(bit [47:0] da, int gap, int extra);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_data = da[47-8*i -: 8];
            if (gap > 0 && i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
                end
            end
        end
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_data = 8'(e * 37 + 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic partial(bit [47:0] da, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_data = da[47-8*i -: 8];
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    localparam bit [47:0] OWN = 48'h02_11_22_33_44_55;

    initial begin
        bit [47:0] mc [6];
        mc[0] = 48'h01_00_5E_00_00_01; mc[1] = 48'h01_00_5E_7F_FF_FA;
        mc[2] = 48'h33_33_00_00_00_01; mc[3] = 48'h01_80_C2_00_00_0E;
        mc[4] = 48'h03_00_00_00_00_01; mc[5] = 48'h09_12_34_56_78_9A;

        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", dec_valid, 1'b0);
        chk("R1", dec_accept, 1'b0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        chk("R1", dec_valid, 1'b0);

        cur_req = "R5";
        send(OWN, 0, 0);                     chk_dec("R5", 1'b1);
        send(48'h02_11_22_33_44_56, 0, 0);   chk_dec("R5", 1'b0);
        send(48'h06_11_22_33_44_55, 0, 0);   chk_dec("R5", 1'b0);

        cur_req = "R6";
        cfg_ucast_chk = 1'b0;
        send(48'h02_11_22_33_44_56, 0, 0);   chk_dec("R6", 1'b1);
        cfg_ucast_chk = 1'b1;

        cur_req = "R7";
        send(48'hFFFF_FFFF_FFFF, 0, 0);      chk_dec("R7", 1'b1);
        cfg_bcast_en = 1'b0; cfg_hash_lo = '1; cfg_hash_hi = '1;
        send(48'hFFFF_FFFF_FFFF, 0, 0);      chk_dec("R7", 1'b0);
        cfg_bcast_en = 1'b1; cfg_hash_lo = '0; cfg_hash_hi = '0;

        cur_req = "R8";
        cfg_mcast_en = 1'b0; cfg_hash_lo = '1; cfg_hash_hi = '1;
        send(mc[0], 0, 0);                   chk_dec("R8", 1'b0);
        cfg_mcast_en = 1'b1;

        cur_req = "R11";
        foreach (mc[i]) begin
            send(mc[i], 0, 1);               chk_dec("R11", 1'b1);
        end

        cur_req = "R9";
        foreach (mc[i]) begin
            bit [63:0] t;
            t = 64'h1 << ref_idx(mc[i]);
            cfg_hash_hi = t[63:32]; cfg_hash_lo = t[31:0];
            send(mc[i], 0, 0);               chk_dec("R9", 1'b1);
            cfg_hash_hi = ~t[63:32]; cfg_hash_lo = ~t[31:0];
            send(mc[i], 0, 0);               chk_dec("R9", 1'b0);
        end

        cur_req = "R10";
        cfg_hash_en = 1'b0; cfg_hash_lo = '0; cfg_hash_hi = '0;
        send(mc[2], 0, 0);                   chk_dec("R10", 1'b1);
        cfg_hash_en = 1'b1;

        cur_req = "R3";
        cfg_promisc = 1'b1; cfg_bcast_en = 1'b0; cfg_mcast_en = 1'b0;
        send(48'h02_99_99_99_99_99, 0, 0);   chk_dec("R3", 1'b1);
        send(48'hFFFF_FFFF_FFFF, 0, 0);      chk_dec("R3", 1'b1);
        send(mc[1], 0, 0);                   chk_dec("R3", 1'b1);
        cfg_promisc = 1'b0;

        cur_req = "R4";
        cfg_addr_filt = 1'b0;
        send(48'h02_99_99_99_99_99, 0, 0);   chk_dec("R4", 1'b1);
        send(mc[3], 0, 0);                   chk_dec("R4", 1'b1);
        cfg_addr_filt = 1'b1; cfg_bcast_en = 1'b1; cfg_mcast_en = 1'b1;

        cur_req = "R2";
        send(48'h02_11_22_33_44_57, 2, 5);   chk_dec("R2", 1'b0);
        cfg_promisc = 1'b1;
        repeat (3) @(negedge clk);
        chk_dec("R2", 1'b0);
        cfg_promisc = 1'b0;
        partial(OWN, 1);
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
        chk("R2", dec_valid, 1'b0);
        chk("R2", dec_accept, 1'b0);

        cur_req = "R12";
        partial(48'h06_00_00_00_00_00, 4);
        send(OWN, 0, 0);                     chk_dec("R12", 1'b1);
        partial(OWN, 3);
        send(48'h02_11_22_00_00_00, 1, 0);   chk_dec("R12", 1'b0);

        repeat (4) @(negedge clk);
        running = 1'b0;
        summary();
    end
endmodule